// File: doc/BRIEF.md
# SPI Flash User-Mode Access Controller

This block gives a processor direct byte-level access to up to five serial flash devices that share one SPI bus. Software programs a small register file through a word-addressed register port. That file holds a configuration word, an address-mode word, a timing word and one control word per chip select. Each control word sets the access mode of its device in bits [1:0] and holds a stop-active flag in bit 2. The stop-active flag drives that device's active-low chip-select pin directly, so software opens and closes flash commands by hand.

A separate flash access window carries 1-, 2- or 4-byte loads and stores. The window address picks the chip select through fixed, parameterised address ranges. When the targeted device is in user mode, each byte of the access becomes one SPI byte exchange in SPI mode 0. The bytes of a multi-byte access go out, and are packed back, lowest byte first.

The window is a valid/ready interface. The requester raises `win_valid` with stable command fields and holds them until it sees `win_ready` high. `win_ready` is high for exactly one cycle, and `win_rdata` is valid in that cycle. The controller applies back-pressure for as long as the serial transfers take, so accesses always complete in order. The register port never stalls.

Top module: `spi_flash_uacc`

## Requirements
- R1: After reset every chip-select control word reads 0x0000_0004 (stop-active set, normal-read mode), the configuration word reads zero, and every `spi_cs_n` pin is high.
- R2: `spi_cs_n[n]` equals bit 2 of control word n (high = deselected). It changes only in the cycle that follows a register write.
- R3: The configuration (word 0x00), address-mode (word 0x01), timing (word 0x25) and control words (word 0x04+n) keep all 32 written bits. A read returns the value with `reg_rvalid` high one cycle after the request.
- R4: Any other word index reads zero and ignores writes. This includes control words for chip selects that are not implemented.
- R5: The number of chip selects equals parameter NUM_CS_REQ, clamped to at most 5.
- R6: A window access to an address outside every chip-select range completes with no SPI traffic, and a read of it returns zero.
- R7: A window write to chip select n completes with no SPI traffic when configuration bit 16+n is clear.
- R8: A user-mode window write sends 1, 2 or 4 bytes for `win_size` 0, 1 or 2/3 respectively, least significant byte first.
- R9: A user-mode window read sends 0x00 for each byte and returns the received bytes packed least significant byte first.
- R10: In modes 0, 1 and 2 a window access produces no SPI traffic, and a read returns zero.
- R11: `win_ready` is high for one cycle per accepted access. `spi_sclk` toggles only while a window request is pending.
- R12: SPI mode 0: `spi_sclk` idles low, each byte goes out MSB first, and `spi_mosi` stays stable while `spi_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_widx | input | 6 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read request |
| reg_rdata | output | 32 | Register read data |
| win_valid | input | 1 | Window request valid; held until ready |
| win_write | input | 1 | 1 = store, 0 = load |
| win_addr | input | WIN_AW | Window byte address |
| win_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| win_wdata | input | 32 | Store data, byte 0 in bits [7:0] |
| win_ready | output | 1 | Access complete (one-cycle pulse) |
| win_rdata | output | 32 | Load data, valid with win_ready |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The bench sweeps every chip select against every access size for both stores and loads. This shows whether decode, byte count and byte order are right for each pairing. The serial slave model answers with a byte sequence that changes on every byte. As a result, a swapped, repeated or dropped byte in a load shows up as a wrong packed word.

The same store is then repeated with the enable bit cleared, in each non-user mode, and outside every range. Each of these cases should produce zero serial bytes, so each gating path is isolated from the others. Register sweeps write distinctive words to valid, unmapped and beyond-count indices. Those sweeps separate storage faults from decode faults.

// File: rtl/spi_uacc_pkg.sv
package spi_uacc_pkg;
  localparam int MAX_CS = 5;
  localparam int CSW = 3;
  localparam logic [5:0] W_CONF   = 6'h00;
  localparam logic [5:0] W_AMODE  = 6'h01;
  localparam logic [5:0] W_CTRL0  = 6'h04;
  localparam logic [5:0] W_TIMING = 6'h25;
  localparam int WEN_LSB  = 16;
  localparam int STOP_BIT = 2;

  typedef enum logic [1:0] {M_NORMAL, M_FAST, M_WRITE, M_USER} acc_mode_e;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_RESP} seq_e;
endpackage

// File: rtl/uacc_regs.sv
module uacc_regs
  import spi_uacc_pkg::*;
#(
  parameter int NCS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [5:0]        widx,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic [31:0]       conf,
  output logic [NCS*32-1:0] ctrl_flat
);
  logic [31:0] conf_q, amode_q, timing_q;
  logic [31:0] ctrl_q [NCS];
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conf_q   <= '0;
      amode_q  <= '0;
      timing_q <= '0;
      for (int i = 0; i < NCS; i++) ctrl_q[i] <= 32'(1) << STOP_BIT;
    end else if (valid && write) begin
      if (widx == W_CONF)   conf_q   <= wdata;
      if (widx == W_AMODE)  amode_q  <= wdata;
      if (widx == W_TIMING) timing_q <= wdata;
      for (int i = 0; i < NCS; i++)
        if (widx == W_CTRL0 + 6'(i)) ctrl_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (widx == W_CONF)   rd_mux = conf_q;
    if (widx == W_AMODE)  rd_mux = amode_q;
    if (widx == W_TIMING) rd_mux = timing_q;
    for (int i = 0; i < NCS; i++)
      if (widx == W_CTRL0 + 6'(i)) rd_mux = ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= valid && !write;
      if (valid && !write) rdata <= rd_mux;
    end
  end

  assign conf = conf_q;

  for (genvar g = 0; g < NCS; g++) begin : g_flat
    assign ctrl_flat[g*32 +: 32] = ctrl_q[g];
  end
endmodule

// File: rtl/uacc_decode.sv
module uacc_decode
  import spi_uacc_pkg::*;
#(
  parameter int NCS = 1,
  parameter int AW  = 28,
  parameter logic [MAX_CS*32-1:0] SEG_BASE = '0,
  parameter logic [MAX_CS*32-1:0] SEG_SIZE = '0
) (
  input  logic [AW-1:0]  addr,
  output logic           hit,
  output logic [CSW-1:0] sel
);
  logic [NCS-1:0] hitv;
  logic [32:0]    a33;

  assign a33 = 33'(addr);

  for (genvar g = 0; g < NCS; g++) begin : g_rng
    localparam logic [32:0] LO = 33'(SEG_BASE[g*32 +: 32]);
    localparam logic [32:0] HI = LO + 33'(SEG_SIZE[g*32 +: 32]);
    assign hitv[g] = (a33 >= LO) && (a33 < HI);
  end

  // lowest chip select wins on overlapping ranges
  always_comb begin
    sel = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (hitv[i]) sel = CSW'(i);
  end

  assign hit = |hitv;
endmodule

// File: rtl/uacc_spi_byte.sv
module uacc_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sh   <= tx;
        cnt  <= '0;
        bitn <= '0;
        sclk <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(HALF - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign mosi = sh[7];
endmodule

// File: rtl/spi_flash_uacc.sv
module spi_flash_uacc
  import spi_uacc_pkg::*;
#(
  parameter int NUM_CS_REQ = 1,
  parameter int WIN_AW     = 28,
  parameter int SCK_HALF   = 2,
  parameter logic [MAX_CS*32-1:0] SEG_BASE = {32'h0A00_0000, 32'h0800_0000,
                                             32'h0600_0000, 32'h0400_0000,
                                             32'h0000_0000},
  parameter logic [MAX_CS*32-1:0] SEG_SIZE = {32'h0200_0000, 32'h0200_0000,
                                             32'h0200_0000, 32'h0200_0000,
                                             32'h0400_0000},
  localparam int NCS = (NUM_CS_REQ > MAX_CS) ? MAX_CS :
                       (NUM_CS_REQ < 1) ? 1 : NUM_CS_REQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [5:0]        reg_widx,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  input  logic              win_valid,
  input  logic              win_write,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [1:0]        win_size,
  input  logic [31:0]       win_wdata,
  output logic              win_ready,
  output logic [31:0]       win_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCS-1:0]    spi_cs_n
);
  logic [31:0]       conf;
  logic [NCS*32-1:0] ctrl_flat;
  logic              dec_hit;
  logic [CSW-1:0]    dec_sel;
  logic [31:0]       sel_ctrl;
  acc_mode_e         sel_mode;
  logic              sel_wen, go;

  seq_e        st;
  logic        wr_q;
  logic [31:0] wd_q, acc_q;
  logic [1:0]  last_q, idx_q;
  logic        eng_start, eng_done;
  logic [7:0]  eng_tx, eng_rx;

  uacc_regs #(.NCS(NCS)) u_regs (
    .clk(clk), .rst_n(rst_n), .valid(reg_valid), .write(reg_write),
    .widx(reg_widx), .wdata(reg_wdata), .rvalid(reg_rvalid),
    .rdata(reg_rdata), .conf(conf), .ctrl_flat(ctrl_flat)
  );

  uacc_decode #(.NCS(NCS), .AW(WIN_AW), .SEG_BASE(SEG_BASE),
                .SEG_SIZE(SEG_SIZE)) u_dec (
    .addr(win_addr), .hit(dec_hit), .sel(dec_sel)
  );

  uacc_spi_byte #(.HALF(SCK_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done),
    .rx(eng_rx)
  );

  // chip-select pins are software-driven by the stop-active flags
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic selected;
    assign selected    = !ctrl_flat[g*32 + STOP_BIT];
    assign spi_cs_n[g] = !selected;
  end

  assign sel_ctrl = ctrl_flat[32*int'(dec_sel) +: 32];
  assign sel_mode = acc_mode_e'(sel_ctrl[1:0]);
  assign sel_wen  = conf[WEN_LSB + int'(dec_sel)];
  assign go       = dec_hit && (sel_mode == M_USER) && (!win_write || sel_wen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      acc_q  <= '0;
      last_q <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (win_valid) begin
          wr_q   <= win_write;
          wd_q   <= win_wdata;
          acc_q  <= '0;
          idx_q  <= '0;
          last_q <= (win_size == 2'd0) ? 2'd0 : (win_size == 2'd1) ? 2'd1 : 2'd3;
          st     <= go ? S_LOAD : S_RESP;
        end
        S_LOAD: st <= S_WAIT;
        S_WAIT: if (eng_done) begin
          if (!wr_q) acc_q[8*int'(idx_q) +: 8] <= eng_rx;
          if (idx_q == last_q) st <= S_RESP;
          else begin
            idx_q <= idx_q + 2'd1;
            st    <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign eng_start = (st == S_LOAD);
  assign eng_tx    = wr_q ? wd_q[8*int'(idx_q) +: 8] : 8'h00;
  assign win_ready = (st == S_RESP);
  assign win_rdata = acc_q;
endmodule

// File: rtl/spi_flash_uacc_chk.sv
module spi_flash_uacc_chk #(
  parameter int NCS = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_valid,
  input logic           reg_write,
  input logic           reg_rvalid,
  input logic           win_valid,
  input logic           win_ready,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n
);
  // R2: pins move only after a register write
  a_r2_cs_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_valid && reg_write) |-> $stable(spi_cs_n));

  // R3: read data follows one cycle later
  a_r3_read_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

  // R11: ready is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);

  // R11: serial clock only inside a pending access
  a_r11_sclk_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> win_valid);

  // R12: clock is low when an access completes
  a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !spi_sclk);

  // R12: data held while the clock is high
  a_r12_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_sclk) && spi_sclk) |-> $stable(spi_mosi));
endmodule

bind spi_flash_uacc spi_flash_uacc_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_rvalid(reg_rvalid), .win_valid(win_valid), .win_ready(win_ready),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/tb_spi_flash_uacc.sv
module tb_spi_flash_uacc;
  localparam int NCS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [5:0]  reg_widx = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        win_valid = 1'b0, win_write = 1'b0;
  logic [27:0] win_addr = '0;
  logic [1:0]  win_size = '0;
  logic [31:0] win_wdata = '0;
  logic        win_ready;
  logic [31:0] win_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_flash_uacc #(.NUM_CS_REQ(7)) dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_widx(reg_widx), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .win_valid(win_valid), .win_write(win_write),
    .win_addr(win_addr), .win_size(win_size), .win_wdata(win_wdata),
    .win_ready(win_ready), .win_rdata(win_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // serial slave model: logs MOSI bytes, answers a changing byte sequence
  logic [7:0]     log_b  [256];
  logic [NCS-1:0] log_cs [256];
  int   nb = 0, bc = 0;
  logic [7:0] shin = '0;

  function automatic logic [7:0] resp(input int k);
    return 8'h3C + 8'(k * 17);
  endfunction

  assign spi_miso = resp(nb)[7 - bc];

  always @(posedge spi_sclk) begin
    shin = {shin[6:0], spi_mosi};
    if (bc == 7) begin
      log_b[nb % 256]  = shin;
      log_cs[nb % 256] = spi_cs_n;
      nb = nb + 1;
      bc = 0;
    end else bc = bc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_widx = w; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_widx = w;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rvalid ? reg_rdata : 32'hBAD0_BAD0;
  endtask

  task automatic win_acc(input logic wr, input logic [27:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    win_valid = 1'b1; win_write = wr; win_addr = a; win_size = sz; win_wdata = wd;
    rd = 32'hDEAD_DEAD;
    n = 0;
    while (n < 4000) begin
      @(negedge clk);
      if (win_ready) begin
        rd = win_rdata;
        break;
      end
      n++;
    end
    if (n >= 4000) chk("R11 window timeout", 32'(n), 32'(0));
    @(negedge clk);
    win_valid = 1'b0;
  endtask

  function automatic logic [27:0] cs_base(input int c);
    return (c == 0) ? 28'h000_0000 : 28'h400_0000 + 28'(c - 1) * 28'h200_0000;
  endfunction

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, wd, exp;
    int nb0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs pins", 32'(spi_cs_n), 32'h1F);
    reg_rd(6'h00, r); chk("R1 conf", r, 32'h0);
    for (int c = 0; c < NCS; c++) begin
      reg_rd(6'h04 + 6'(c), r); chk("R1 ctrl", r, 32'h4);
    end

    // R3 storage, R4 unmapped, R5 clamp
    reg_wr(6'h25, 32'hDEAD_BEEF); reg_rd(6'h25, r); chk("R3 timing", r, 32'hDEAD_BEEF);
    reg_wr(6'h01, 32'h0000_001F); reg_rd(6'h01, r); chk("R3 amode", r, 32'h1F);
    reg_wr(6'h00, 32'hA5A5_5A5A); reg_rd(6'h00, r); chk("R3 conf", r, 32'hA5A5_5A5A);
    for (int w = 0; w < 64; w++) begin
      if (w == 0 || w == 1 || w == 'h25 || (w >= 4 && w < 4 + NCS)) continue;
      reg_wr(6'(w), 32'hFFFF_FFFF); reg_rd(6'(w), r);
      chk($sformatf("R4 unmapped word %0d", w), r, 32'h0);
    end
    reg_wr(6'h08, 32'h0000_0007); reg_rd(6'h08, r); chk("R5 fifth ctrl present", r, 32'h7);
    reg_rd(6'h09, r); chk("R5 sixth ctrl absent", r, 32'h0);
    reg_rd(6'h25, r); chk("R4 timing unchanged", r, 32'hDEAD_BEEF);

    // R2 chip-select pins follow the stop flag
    for (int c = 0; c < NCS; c++) begin
      reg_wr(6'h04 + 6'(c), 32'h3);
      chk("R2 cs select", 32'(spi_cs_n), 32'h1F & ~(32'h1 << c));
      reg_wr(6'h04 + 6'(c), 32'h7);
      chk("R2 cs deselect", 32'(spi_cs_n), 32'h1F);
    end

    // R8 R9 sweep over chip selects and sizes
    reg_wr(6'h00, 32'h001F_0000);
    for (int c = 0; c < NCS; c++) begin
      reg_wr(6'h04 + 6'(c), 32'h3);
      for (int sz = 0; sz < 4; sz++) begin
        n  = nbytes(sz);
        wd = 32'h1122_3344 + 32'(c) * 32'h0101_0101 + 32'(sz) * 32'h1000_0010;
        nb0 = nb;
        win_acc(1'b1, cs_base(c) + 28'h10, 2'(sz), wd, r);
        chk("R8 write byte count", 32'(nb - nb0), 32'(n));
        for (int i = 0; i < n; i++) begin
          chk("R8 write byte", 32'(log_b[(nb0 + i) % 256]), 32'(wd[8*i +: 8]));
          chk("R8 write cs", 32'(log_cs[(nb0 + i) % 256]), 32'h1F & ~(32'h1 << c));
        end
        chk("R12 sclk idle", 32'(spi_sclk), 32'h0);
        nb0 = nb;
        exp = '0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = resp(nb0 + i);
        win_acc(1'b0, cs_base(c) + 28'h20, 2'(sz), 32'hFFFF_FFFF, r);
        chk("R9 read data", r, exp);
        chk("R9 read byte count", 32'(nb - nb0), 32'(n));
        for (int i = 0; i < n; i++)
          chk("R9 dummy byte", 32'(log_b[(nb0 + i) % 256]), 32'h0);
      end
      reg_wr(6'h04 + 6'(c), 32'h7);
    end

    // R7 write enable gating
    reg_wr(6'h04 + 6'd2, 32'h3);
    reg_wr(6'h00, 32'h001B_0000);
    nb0 = nb;
    win_acc(1'b1, cs_base(2), 2'd2, 32'hCAFE_F00D, r);
    chk("R7 gated write no traffic", 32'(nb - nb0), 32'h0);
    nb0 = nb;
    win_acc(1'b0, cs_base(2), 2'd0, 32'h0, r);
    chk("R7 read still allowed", 32'(nb - nb0), 32'h1);
    chk("R7 read data", r, 32'(resp(nb0)));
    reg_wr(6'h04 + 6'd2, 32'h7);

    // R10 non-user modes
    reg_wr(6'h00, 32'h001F_0000);
    for (int m = 0; m < 3; m++) begin
      reg_wr(6'h05, 32'(m));
      nb0 = nb;
      win_acc(1'b1, cs_base(1), 2'd2, 32'h0102_0304, r);
      win_acc(1'b0, cs_base(1), 2'd2, 32'h0, r);
      chk("R10 mode read zero", r, 32'h0);
      chk("R10 mode no traffic", 32'(nb - nb0), 32'h0);
    end

    // R6 outside every range
    reg_wr(6'h05, 32'h3);
    nb0 = nb;
    win_acc(1'b0, 28'hC00_0000, 2'd2, 32'h0, r);
    chk("R6 outside read zero", r, 32'h0);
    win_acc(1'b1, 28'hFFF_FFFC, 2'd2, 32'h1234_5678, r);
    chk("R6 outside no traffic", 32'(nb - nb0), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule